// File: doc/BRIEF.md
# Hiccup-Restart Fault Manager

This block supervises a synchronous buck controller. It watches four qualified digital inputs: an over-current trip, an under-voltage comparator, an over-temperature comparator and a soft-start-done flag. From them it decides whether the power stage keeps switching, pauses for a timed hiccup and then restarts, or shuts down for good. Its synchronous active-low reset doubles as the power-on-reset. Reset is the only event that clears a shutdown or the count of over-current retries already used.

Each fault class has its own restart policy. Under-voltage restarts without limit. Over-current restarts a fixed number of times and latches off on the next trip. Over-temperature latches off at once. Under-voltage is only watched after soft start has finished, and the comparator must stay high for a qualification window before it counts. During a hiccup both gate drivers are disabled for a programmable number of clock cycles. At the end of that time a one-cycle restart request goes to the soft-start sequencer, and the gates are enabled again.

Top module: `hiccup_fault_mgr`

## Requirements
- R1: While reset is low, and in the first cycle after it, gate_en_o is 1, restart_req_o is 0 and latched_off_o is 0. Reset clears a latched shutdown and the over-current retry count.
- R2: If ot_cmp_i is high at a clock edge in any state that is not latched, then from the next cycle latched_off_o is 1, gate_en_o is 0, and no restart request follows. This includes a state where a hiccup is in progress.
- R3: If oc_trip_i is high at an edge while gates are enabled and retries remain, gate_en_o is 0 for exactly OFF_CYC cycles. In the cycle where gate_en_o returns to 1, restart_req_o is 1, and it lasts one cycle.
- R4: The first MAX_RETRY over-current trips after reset each cause a hiccup. The next trip latches the block off.
- R5: An under-voltage fault is taken when uv_cmp_i has been high at UV_FILT_CYC consecutive edges while gates are enabled and ss_done_i is 1. It starts the same hiccup as R3. A high run of fewer edges has no effect.
- R6: While ss_done_i is 0, uv_cmp_i is ignored and does not advance the qualification count. The count starts from zero when ss_done_i rises.
- R7: Under-voltage hiccups repeat without limit and do not use up over-current retries.
- R8: When faults arrive together the priority is over-temperature, then over-current, then under-voltage. A combined trip is handled, and counted, as the higher-priority class.
- R9: During a hiccup, oc_trip_i and uv_cmp_i are ignored. The off time is not extended, and no retry is used up.
- R10: Once latched off, the outputs stay at gate_en_o=0, restart_req_o=0, latched_off_o=1 until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also the power-on-reset |
| oc_trip_i | input | 1 | Qualified over-current trip |
| uv_cmp_i | input | 1 | Under-voltage comparator output |
| ot_cmp_i | input | 1 | Over-temperature comparator output |
| ss_done_i | input | 1 | Soft start has finished |
| gate_en_o | output | 1 | Enable for both gate drivers |
| restart_req_o | output | 1 | One-cycle restart request to the soft-start sequencer |
| latched_off_o | output | 1 | Controller is shut down until reset |

## Verification
The bench sweeps the length of the under-voltage pulse from one cycle to two beyond the window. This shows exactly where a pulse stops being rejected and starts causing a hiccup, and it checks that the remaining off time is correct in each case. Over-current trips are issued in sequence until the block latches, both before and after stretches of under-voltage hiccups. The point where it latches shows whether retries are counted only for over-current. Coincident fault pairs test the priority order. Noise on the fault inputs during a hiccup, and after the block has latched, shows that those inputs are ignored. Holding under-voltage high while soft start is still running shows that the window starts from zero when soft start completes.

// File: rtl/hfm_pkg.sv
// Package: shared state and event types for the hiccup fault manager.
// Assumes: fault inputs are already synchronous to clk.
package hfm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HICCUP = 2'd1,
        ST_LATCH  = 2'd2
    } hfm_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_UV   = 2'd1,
        EV_OC   = 2'd2,
        EV_OT   = 2'd3
    } hfm_event_e;

    // Resolve coincident faults: temperature beats current beats voltage.
    function automatic hfm_event_e pick_event(input logic ot, input logic oc, input logic uv);
        if (ot)      return EV_OT;
        else if (oc) return EV_OC;
        else if (uv) return EV_UV;
        else         return EV_NONE;
    endfunction

endpackage

// File: rtl/hfm_uv_filter.sv
// Module: under-voltage qualifier. Raises fault_o in the cycle where uv_i
// has been high for FILT_CYC consecutive edges while enable_i was high.
// Assumes: FILT_CYC >= 1; a drop of enable_i or uv_i restarts the window.
module hfm_uv_filter #(
    parameter int FILT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic uv_i,
    output logic fault_o
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive qualifying high samples, clear on any break.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || !uv_i) begin
            run_cnt <= '0;
        end else if (run_cnt != LAST) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign fault_o = enable_i && uv_i && (run_cnt == LAST);
endmodule

// File: rtl/hfm_hiccup_timer.sv
// Module: hiccup off-time counter. While run_i is high it counts cycles.
// expire_o is high in the OFF_CYC-th cycle of a run.
// Assumes: OFF_CYC >= 2; run_i drops right after expiry.
module hfm_hiccup_timer #(
    parameter int OFF_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = (OFF_CYC > 1) ? $clog2(OFF_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(OFF_CYC - 1);

    logic [TW-1:0] tick_cnt;

    // Advance while a hiccup runs, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tick_cnt <= '0;
        end else if (tick_cnt != LAST) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign expire_o = run_i && (tick_cnt == LAST);
endmodule

// File: rtl/hfm_retry_budget.sv
// Module: over-current retry budget. Each consume_i pulse uses up one
// retry. exhausted_o is high once MAX_RETRY retries have been used.
// Assumes: the caller never consumes while exhausted_o is high.
module hfm_retry_budget #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic consume_i,
    output logic exhausted_o
);
    localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

    logic [RW-1:0] used_cnt;

    // Record retries taken since power-on-reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_cnt <= '0;
        end else if (consume_i && used_cnt != LIMIT) begin
            used_cnt <= used_cnt + 1'b1;
        end
    end

    assign exhausted_o = (used_cnt == LIMIT);
endmodule

// File: rtl/hiccup_fault_mgr.sv
// Module: top of the hiccup fault manager. This is a three-state supervisor:
// run (gates on), hiccup (gates off for a timed interval), latched
// (gates off until reset).
// Assumes: rst_n is synchronous active-low and acts as power-on-reset.
// All fault inputs are synchronous to clk.
module hiccup_fault_mgr
    import hfm_pkg::*;
#(
    parameter int OFF_CYC     = 100000,
    parameter int UV_FILT_CYC = 1000,
    parameter int MAX_RETRY   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_trip_i,
    input  logic uv_cmp_i,
    input  logic ot_cmp_i,
    input  logic ss_done_i,
    output logic gate_en_o,
    output logic restart_req_o,
    output logic latched_off_o
);
    hfm_state_e state_q, state_d;
    hfm_event_e run_ev;
    logic       uv_fault, uv_enable, hic_run, hic_expire;
    logic       retry_out, retry_take, req_d;

    assign uv_enable = (state_q == ST_RUN) && ss_done_i;
    assign hic_run   = (state_q == ST_HICCUP);

    hfm_uv_filter #(.FILT_CYC(UV_FILT_CYC)) uv_filt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (uv_enable),
        .uv_i     (uv_cmp_i),
        .fault_o  (uv_fault)
    );

    hfm_hiccup_timer #(.OFF_CYC(OFF_CYC)) hic_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (hic_run),
        .expire_o (hic_expire)
    );

    hfm_retry_budget #(.MAX_RETRY(MAX_RETRY)) budget_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .consume_i   (retry_take),
        .exhausted_o (retry_out)
    );

    // Pick the winning fault in the current cycle.
    assign run_ev = pick_event(ot_cmp_i, oc_trip_i, uv_fault);

    // Next-state decision and side effects.
    always_comb begin
        state_d    = state_q;
        retry_take = 1'b0;
        req_d      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                unique case (run_ev)
                    EV_OT: state_d = ST_LATCH;
                    EV_OC: begin
                        if (retry_out) begin
                            state_d = ST_LATCH;
                        end else begin
                            state_d    = ST_HICCUP;
                            retry_take = 1'b1;
                        end
                    end
                    EV_UV:   state_d = ST_HICCUP;
                    default: state_d = ST_RUN;
                endcase
            end
            ST_HICCUP: begin
                if (ot_cmp_i) begin
                    state_d = ST_LATCH;
                end else if (hic_expire) begin
                    state_d = ST_RUN;
                    req_d   = 1'b1;
                end
            end
            default: state_d = ST_LATCH;
        endcase
    end

    // State and restart-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_RUN;
            restart_req_o <= 1'b0;
        end else begin
            state_q       <= state_d;
            restart_req_o <= req_d;
        end
    end

    assign gate_en_o     = (state_q == ST_RUN);
    assign latched_off_o = (state_q == ST_LATCH);
endmodule

// File: rtl/hfm_checker.sv
// Module: property checker for hiccup_fault_mgr. It observes ports only
// and is bound to every instance of the top.
module hfm_checker (
    input logic clk,
    input logic rst_n,
    input logic oc_trip_i,
    input logic uv_cmp_i,
    input logic ot_cmp_i,
    input logic ss_done_i,
    input logic gate_en_o,
    input logic restart_req_o,
    input logic latched_off_o
);
    p_ot_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_cmp_i && !latched_off_o) |=> (latched_off_o && !gate_en_o));

    p_oc_gates_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && oc_trip_i) |=> !gate_en_o);

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |=> !restart_req_o);

    p_req_on_reenable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> (gate_en_o && !$past(gate_en_o)));

    p_uv_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && !ss_done_i && !oc_trip_i && !ot_cmp_i) |=> gate_en_o);

    p_hiccup_no_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en_o && !latched_off_o && !ot_cmp_i) |=> !latched_off_o);

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off_o |=> (latched_off_o && !gate_en_o && !restart_req_o));
endmodule

bind hiccup_fault_mgr hfm_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .oc_trip_i     (oc_trip_i),
    .uv_cmp_i      (uv_cmp_i),
    .ot_cmp_i      (ot_cmp_i),
    .ss_done_i     (ss_done_i),
    .gate_en_o     (gate_en_o),
    .restart_req_o (restart_req_o),
    .latched_off_o (latched_off_o)
);

// File: tb/hiccup_fault_mgr_tb_top.sv
module hiccup_fault_mgr_tb_top;
    localparam int HC = 20;
    localparam int UF = 8;
    localparam int NR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0, uv = 1'b0, ot = 1'b0, ssd = 1'b1;
    logic gate_en, req, latched;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    hiccup_fault_mgr #(.OFF_CYC(HC), .UV_FILT_CYC(UF), .MAX_RETRY(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .oc_trip_i(oc), .uv_cmp_i(uv), .ot_cmp_i(ot),
        .ss_done_i(ssd), .gate_en_o(gate_en), .restart_req_o(req), .latched_off_o(latched)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; oc = 0; uv = 0; ot = 0; ssd = 1;
        repeat (2) @(negedge clk);
        check(gate_en && !req && !latched, "R1 reset outputs", {gate_en, req, latched}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(gate_en && !req && !latched, "R1 after release", {gate_en, req, latched}, 3'b100);
    endtask

    // Count negedges with gates off; optional noise on oc/uv mid-hiccup.
    task automatic count_off(input bit noisy, output int n, output bit rq);
        n = 0;
        while (!gate_en && !latched && n < 10 * HC) begin
            if (noisy && n == 3) begin oc = 1; uv = 1; end
            if (noisy && n == 6) begin oc = 0; uv = 0; end
            n++;
            @(negedge clk);
        end
        rq = req;
    endtask

    task automatic oc_hiccup(input string tag, input bit noisy);
        int n; bit rq;
        oc = 1; @(negedge clk); oc = 0;
        check(!gate_en && !latched, tag, {gate_en, latched}, 0);
        count_off(noisy, n, rq);
        check(n == HC && rq && !latched, tag, n, HC);
        @(negedge clk);
        check(!req && gate_en, {tag, " req one cycle"}, req, 0);
    endtask

    task automatic oc_latch(input string tag);
        oc = 1; @(negedge clk); oc = 0;
        check(latched && !gate_en && !req, tag, {latched, gate_en, req}, 3'b100);
    endtask

    task automatic uv_pulse(input int len);
        int first, n; bit rq, ok;
        first = -1;
        uv = 1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (!gate_en && first < 0) first = i + 1;
        end
        uv = 0;
        if (len >= UF) begin
            check(first == UF, "R5 trip point", first, UF);
            count_off(1'b0, n, rq);
            check(n == HC + UF - len && rq, "R5 off time", n, HC + UF - len);
            @(negedge clk);
        end else begin
            ok = (first < 0);
            for (int i = 0; i < UF + 2; i++) begin
                @(negedge clk);
                if (!gate_en || req) ok = 0;
            end
            check(ok, "R5 short pulse rejected", first, -1);
        end
    endtask

    task automatic latch_hold(input string tag, input int cycles);
        bit ok;
        ok = 1;
        for (int i = 0; i < cycles; i++) begin
            oc = i[0]; uv = i[1]; ssd = i[2];
            @(negedge clk);
            if (!latched || gate_en || req) ok = 0;
        end
        oc = 0; uv = 0; ssd = 1;
        check(ok, tag, ok, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        int first, n; bit rq, ok;

        // R4 retry sequence with noise during one hiccup (R9)
        do_reset();
        oc_hiccup("R4 oc retry 1", 1'b0);
        oc_hiccup("R9 noisy hiccup keeps off time", 1'b1);
        oc_hiccup("R4 oc retry 3", 1'b0);
        oc_latch("R4 fourth oc latches");
        latch_hold("R10 latch holds under input noise", 3 * HC);

        // R1: reset clears latch and retry count
        do_reset();
        oc_hiccup("R1 retry count cleared", 1'b0);

        // R5 sweep of UV pulse length; R7 unlimited UV retries
        for (int len = 1; len <= UF + 2; len++) uv_pulse(len);
        for (int k = 0; k < 5; k++) uv_pulse(UF);
        oc_hiccup("R7 uv did not use retries (2)", 1'b0);
        oc_hiccup("R7 uv did not use retries (3)", 1'b0);
        oc_latch("R7 latch after oc budget");

        // R6: UV ignored before soft start completes
        do_reset();
        ssd = 0; uv = 1; ok = 1;
        for (int i = 0; i < 3 * UF; i++) begin
            @(negedge clk);
            if (!gate_en || req) ok = 0;
        end
        check(ok, "R6 uv ignored in soft start", ok, 1);
        ssd = 1; first = -1;
        for (int i = 0; i < 2 * UF && first < 0; i++) begin
            @(negedge clk);
            if (!gate_en) first = i + 1;
        end
        uv = 0;
        check(first == UF, "R6 window starts at ss_done", first, UF);
        count_off(1'b0, n, rq);
        check(n == HC && rq, "R6 hiccup after window", n, HC);

        // R8: OT beats OC
        do_reset();
        ot = 1; oc = 1; @(negedge clk); ot = 0; oc = 0;
        check(latched && !gate_en, "R8 ot over oc", latched, 1);
        latch_hold("R8 no restart after ot", HC + 5);

        // R8: OC beats UV, counted as OC
        do_reset();
        uv = 1;
        repeat (UF - 1) @(negedge clk);
        oc = 1; @(negedge clk); oc = 0; uv = 0;
        count_off(1'b0, n, rq);
        check(n == HC && rq, "R8 combined trip hiccup", n, HC);
        @(negedge clk);
        oc_hiccup("R8 after combined, retry 2", 1'b0);
        oc_hiccup("R8 after combined, retry 3", 1'b0);
        oc_latch("R8 combined counted as oc");

        // R2: OT during hiccup latches at once
        do_reset();
        oc = 1; @(negedge clk); oc = 0;
        repeat (3) @(negedge clk);
        ot = 1; @(negedge clk); ot = 0;
        check(latched && !gate_en && !req, "R2 ot during hiccup", latched, 1);
        latch_hold("R2 no restart after ot", 2 * HC);

        done = 1;
        finish_run();
    end
endmodule